// File: doc/BRIEF.md
# Event Packet Serializer

This block takes one stored trigger event at a time from an event buffer and sends it as a fixed 192-bit serial packet, most significant bit first, at one bit per clock. Each packet consists of three header words, eight words of channel hits and a 16-bit checksum. Each header word starts with its own 4-bit marker. The bunch count, event count, flag bits and channel hits come from the buffer. The chip identifier is a static input. A data-valid strobe frames the packet.

The buffer offers an event with a valid/ready handshake. The serializer copies the whole event on acceptance, so the buffer may change its outputs at once. While one event is pending behind the current packet, the serializer takes it in the clock cycle that carries the last checksum bit, so frames follow each other with no idle gap.

Top module: `evt_pkt_serializer`

## Requirements
- R1: After reset, `ser_valid` is 0, `ser_out` is 0 and `evt_ready` is 1.
- R2: Packet bits 0..15 are the marker 1010 followed by bunch count bits 11 down to 0.
- R3: Packet bits 16..31 are the marker 1100, then event count bits 7..0, then flag bits 3..0.
- R4: Packet bits 32..47 are the marker 1110 followed by chip identifier bits 11..0.
- R5: Packet bits 48..175 carry the channel hits, channel 127 first and channel 0 last.
- R6: Packet bits 176..191 carry a CRC-16 of packet bits 0..175, sent most significant bit first. It uses polynomial 0x1021, starts from 0xFFFF, and has no final inversion or bit reflection.
- R7: `ser_valid` goes high in the cycle after an accepted handshake and stays high for exactly 192 cycles, one per packet bit.
- R8: While `ser_valid` is low, `ser_out` is 0.
- R9: `evt_ready` is low during the first 191 bits of a packet and high during the last bit. An event offered at that point starts its packet in the very next cycle.
- R10: Changes on the event inputs or on `chip_id` after acceptance do not alter the packet being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one packet bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event buffer offers an event |
| evt_ready | output | 1 | Serializer can accept an event this cycle |
| evt_bc | input | 12 | Bunch count of the offered event |
| evt_ec | input | 8 | Event count of the offered event |
| evt_flags | input | 4 | Flag bits of the offered event |
| evt_chan | input | 128 | Channel hit bits, bit i is channel i |
| chip_id | input | 12 | Static chip identifier |
| ser_out | output | 1 | Serial packet data |
| ser_valid | output | 1 | High for the duration of a packet |

## Verification
A bit counter that is off by one gives a strobe of the wrong length. It also moves the ready pulse off the last bit, and both show up at the end of the first packet. A shift register or checksum that is wrong in its state shows up as wrong bits in the header marker or in the trailing 16 bits of that same packet, because every packet is compared bit for bit with a frame that is rebuilt independently, with the checksum computed by polynomial division. Back-to-back traffic shows whether a stale count or late reload shifts the second frame by even one cycle.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  parameter int WORD_W   = 16;
  parameter int BC_W     = 12;
  parameter int EC_W     = 8;
  parameter int FLAG_W   = 4;
  parameter int ID_W     = 12;
  parameter int CHAN_N   = 128;
  parameter int CRC_W    = 16;
  parameter int MARK_W   = 4;
  parameter int HDR_WORDS = 3;
  localparam int HDR_W   = HDR_WORDS * WORD_W;
  localparam int BODY_W  = HDR_W + CHAN_N;
  localparam int PKT_W   = BODY_W + CRC_W;
  localparam int CNT_W   = $clog2(PKT_W);

  localparam logic [MARK_W-1:0] MARK_BC = 4'b1010;
  localparam logic [MARK_W-1:0] MARK_EC = 4'b1100;
  localparam logic [MARK_W-1:0] MARK_ID = 4'b1110;
  localparam logic [CRC_W-1:0]  CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0]  CRC_SEED = 16'hFFFF;

  // One serial step of the checksum: feedback of the top bit with the new bit.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  // Channel 127 leads, so the hit vector is placed unreversed.
  function automatic logic [BODY_W-1:0] frame_of(
    input logic [BC_W-1:0]   bc,
    input logic [EC_W-1:0]   ec,
    input logic [FLAG_W-1:0] fl,
    input logic [ID_W-1:0]   id,
    input logic [CHAN_N-1:0] ch);
    return {MARK_BC, bc, MARK_EC, ec, fl, MARK_ID, id, ch};
  endfunction
endpackage

// File: rtl/pkt_bit_counter.sv
module pkt_bit_counter
  import pkt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last_bit,
  output logic in_body,
  output logic in_crc
);
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);
  localparam logic [CNT_W-1:0] BODY_END = CNT_W'(BODY_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == LAST) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign last_bit = busy && (cnt_q == LAST);
  assign in_body  = busy && (cnt_q < BODY_END);
  assign in_crc   = busy && (cnt_q >= BODY_END);

  // R7: inside a packet the position advances by one every cycle
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last_bit && !start |=> busy && cnt_q == $past(cnt_q) + 1'b1);
  // R7: counter leaves the packet after the last position
  a_r7_count_end: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit && !start |=> !busy);
endmodule

// File: rtl/pkt_shift_reg.sv
module pkt_shift_reg
  import pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [BODY_W-1:0] frame,
  output logic              msb
);
  logic [BODY_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= frame;
    else if (shift) sh_q <= {sh_q[BODY_W-2:0], 1'b0};
  end

  assign msb = sh_q[BODY_W-1];

  // R10: without load or shift the captured frame stays put
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !shift |=> $stable(sh_q));
endmodule

// File: rtl/pkt_crc_engine.sv
module pkt_crc_engine
  import pkt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic feed,
  input  logic data_bit,
  input  logic drain,
  output logic crc_msb
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '0;
    else if (init)   crc_q <= CRC_SEED;
    else if (feed)   crc_q <= crc_step(crc_q, data_bit);
    else if (drain)  crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  assign crc_msb = crc_q[CRC_W-1];

  // R6: feeding and draining never overlap
  a_r6_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(feed && drain));
endmodule

// File: rtl/evt_pkt_serializer.sv
module evt_pkt_serializer
  import pkt_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_valid,
  output logic         evt_ready,
  input  logic [11:0]  evt_bc,
  input  logic [7:0]   evt_ec,
  input  logic [3:0]   evt_flags,
  input  logic [127:0] evt_chan,
  input  logic [11:0]  chip_id,
  output logic         ser_out,
  output logic         ser_valid
);
  logic accept, busy, last_bit, in_body, in_crc;
  logic body_bit, crc_bit;
  logic [BODY_W-1:0] frame;

  assign evt_ready = !busy || last_bit;
  assign accept    = evt_valid && evt_ready;
  assign frame     = frame_of(evt_bc, evt_ec, evt_flags, chip_id, evt_chan);

  pkt_bit_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .busy(busy), .last_bit(last_bit), .in_body(in_body), .in_crc(in_crc));

  pkt_shift_reg u_sh (
    .clk(clk), .rst_n(rst_n), .load(accept), .shift(in_body),
    .frame(frame), .msb(body_bit));

  pkt_crc_engine u_crc (
    .clk(clk), .rst_n(rst_n), .init(accept), .feed(in_body && !accept),
    .data_bit(body_bit), .drain(in_crc && !accept), .crc_msb(crc_bit));

  assign ser_out   = in_body ? body_bit : (in_crc ? crc_bit : 1'b0);
  assign ser_valid = busy;

  // R8: line stays low while idle
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> !ser_out);
  // R7: an accepted event opens a packet next cycle
  a_r7_open: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ser_valid);
  // R2: every packet starts with the leading 1 of its marker
  a_r2_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ser_out);
  // R9: no acceptance in the middle of a packet
  a_r9_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid && !last_bit |-> !evt_ready);
endmodule

// File: tb/tb_evt_pkt_serializer.sv
module tb_evt_pkt_serializer;
  logic clk = 0, rst_n = 0;
  logic evt_valid = 0;
  logic evt_ready;
  logic [11:0] evt_bc = 0;
  logic [7:0] evt_ec = 0;
  logic [3:0] evt_flags = 0;
  logic [127:0] evt_chan = 0;
  logic [11:0] chip_id = 0;
  logic ser_out, ser_valid;

  int checks = 0, errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  evt_pkt_serializer dut (.clk(clk), .rst_n(rst_n), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_bc(evt_bc), .evt_ec(evt_ec), .evt_flags(evt_flags),
    .evt_chan(evt_chan), .chip_id(chip_id), .ser_out(ser_out), .ser_valid(ser_valid));

  // monitor
  logic [191:0] cap;
  int idx = 0, npk = 0, idle_bad = 0;
  logic [191:0] pkts [0:15];
  int pstart [0:15];
  int plen   [0:15];
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (ser_valid) begin
        if (idx == 0 && npk < 16) pstart[npk] = cyc;
        cap[191-idx] = ser_out;
        idx++;
        if (idx == 192) begin
          if (npk < 16) begin pkts[npk] = cap; plen[npk] = 192; end
          npk++;
          idx = 0;
        end
      end else begin
        if (ser_out) idle_bad++;
        if (idx != 0) begin
          if (npk < 16) plen[npk] = idx;
          npk++;
          idx = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [175:0] m);
    logic [191:0] v;
    v = {m, 16'h0};
    v[191:176] = v[191:176] ^ 16'hFFFF;
    for (int i = 191; i >= 16; i--)
      if (v[i]) v[i -: 17] = v[i -: 17] ^ 17'h11021;
    return v[15:0];
  endfunction

  function automatic logic [191:0] ref_pkt(input logic [11:0] bc, input logic [7:0] ec,
      input logic [3:0] fl, input logic [11:0] id, input logic [127:0] ch);
    logic [175:0] b;
    b = {4'b1010, bc, 4'b1100, ec, fl, 4'b1110, id, ch};
    return {b, ref_crc(b)};
  endfunction

  task automatic cmp_pkt(input int k, input logic [191:0] e, input string tag);
    logic [191:0] a;
    a = pkts[k];
    chk(plen[k] == 192, {"R7 length ", tag}, 192'(plen[k]), 192);
    chk(a[191:176] == e[191:176], {"R2 word0 ", tag}, 192'(a[191:176]), 192'(e[191:176]));
    chk(a[175:160] == e[175:160], {"R3 word1 ", tag}, 192'(a[175:160]), 192'(e[175:160]));
    chk(a[159:144] == e[159:144], {"R4 word2 ", tag}, 192'(a[159:144]), 192'(e[159:144]));
    chk(a[143:16] == e[143:16], {"R5 channels ", tag}, 192'(a[143:16]), 192'(e[143:16]));
    chk(a[15:0] == e[15:0], {"R6 crc ", tag}, 192'(a[15:0]), 192'(e[15:0]));
  endtask

  task automatic drive(input logic [11:0] bc, input logic [7:0] ec, input logic [3:0] fl,
      input logic [11:0] id, input logic [127:0] ch);
    evt_bc = bc; evt_ec = ec; evt_flags = fl; chip_id = id; evt_chan = ch;
  endtask

  task automatic wait_pkts(input int n);
    int t = 0;
    while (npk < n && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!ser_valid && !ser_out && evt_ready, "R1 reset state",
        192'({ser_valid, ser_out, evt_ready}), 192'(3'b001));
  endtask

  task automatic t_single(input logic [11:0] bc, input logic [7:0] ec, input logic [3:0] fl,
      input logic [11:0] id, input logic [127:0] ch, input string tag);
    int n0;
    logic [191:0] e;
    n0 = npk;
    e = ref_pkt(bc, ec, fl, id, ch);
    while (!evt_ready) @(negedge clk);
    drive(bc, ec, fl, id, ch);
    evt_valid = 1;
    @(negedge clk);
    evt_valid = 0;
    chk(ser_valid && ser_out, {"R7 opens after accept ", tag}, 192'({ser_valid, ser_out}), 192'(2'b11));
    // R10: scramble inputs after acceptance
    drive(~bc, ~ec, ~fl, ~id, ~ch);
    repeat (50) @(negedge clk);
    chk(!evt_ready, {"R9 ready low mid packet ", tag}, 192'(evt_ready), 0);
    wait_pkts(n0 + 1);
    @(negedge clk);
    chk(!ser_valid && !ser_out, {"R8 idle after packet ", tag}, 192'({ser_valid, ser_out}), 0);
    cmp_pkt(n0, e, {"R10 ", tag});
  endtask

  task automatic t_back2back;
    int n0, gapok;
    logic [191:0] e0, e1;
    n0 = npk;
    e0 = ref_pkt(12'h123, 8'h45, 4'h6, 12'h789, {4{32'hDEADBEEF}});
    e1 = ref_pkt(12'hFED, 8'hCB, 4'hA, 12'h987, {4{32'h01234567}});
    while (!evt_ready) @(negedge clk);
    drive(12'h123, 8'h45, 4'h6, 12'h789, {4{32'hDEADBEEF}});
    evt_valid = 1;
    @(negedge clk);
    drive(12'hFED, 8'hCB, 4'hA, 12'h987, {4{32'h01234567}});
    gapok = 0;
    while (!evt_ready) @(negedge clk);
    chk(idx == 191, "R9 ready only on final bit", 192'(idx), 191);
    @(negedge clk);
    evt_valid = 0;
    wait_pkts(n0 + 2);
    chk(pstart[n0 + 1] - pstart[n0] == 192, "R9 no gap between frames",
        192'(pstart[n0 + 1] - pstart[n0]), 192);
    cmp_pkt(n0, e0, "b2b first");
    cmp_pkt(n0 + 1, e1, "b2b second");
  endtask

  initial begin
    int wd;
    wd = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_single(12'hABC, 8'h5A, 4'h3, 12'h5C3, 128'h8000_0000_0000_0000_0000_0000_0000_0001, "mixed");
        t_single(12'h000, 8'h00, 4'h0, 12'h000, 128'h0, "zeros");
        t_single(12'hFFF, 8'hFF, 4'hF, 12'hFFF, {128{1'b1}}, "ones");
        t_single(12'h801, 8'h81, 4'h9, 12'h001, {16{8'hA5}}, "pattern");
        t_back2back();
        chk(idle_bad == 0, "R8 no data while idle", 192'(idle_bad), 0);
      end
      begin
        repeat (100000) @(negedge clk);
        wd = 1;
      end
    join_any
    if (wd) chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule